// File: doc/BRIEF.md
# Proximity Window Interrupt with Persistence Filter

This block turns a stream of 16-bit proximity conversion results into a latched interrupt. Each result arrives with a one-cycle valid strobe. The block tests it against a programmable window formed by a low and a high threshold. A result lies outside the window when it is strictly below the low threshold or strictly above the high threshold. A 4-bit persistence setting decides how many outside results in a row must arrive before an interrupt is raised. A setting of zero raises an interrupt on every result, whatever the window test gives.

Once raised, the interrupt is level-style. It stays set until the register interface sends a one-cycle clear strobe. The pending flag is output as a status bit. The same flag drives the enable of an external active-low open-drain pad: a 1 means the pad pulls the line low. The threshold registers, the conversion sequencer and the pad itself sit outside this block.

Top module: `prox_irq_gen`

## Requirements
- R1: After reset the pending flag is 0, the pad drive output is 0 and the consecutive-outside count is 0.
- R2: A result is outside the window only when it is strictly less than the low threshold or strictly greater than the high threshold. A result equal to either threshold is inside.
- R3: With persistence 0 and the enable set, every valid result sets the pending flag one clock after its strobe, whether it is inside or outside the window.
- R4: With persistence N (1 to 15) and the enable set, the pending flag is set one clock after the strobe of the N-th consecutive outside result, and not earlier.
- R5: A valid result that is inside the window resets the consecutive count to 0.
- R6: The consecutive count saturates at 15 and does not wrap. Once it is saturated, every further outside result qualifies for persistence 15.
- R7: Once set, the pending flag stays at 1 until a clear strobe. It reads 0 one clock after a clear strobe when no qualifying result arrives in the same cycle.
- R8: While the enable is 0, no result sets the pending flag, but the consecutive count still advances.
- R9: When a clear strobe and a qualifying result arrive in the same cycle, the pending flag remains 1.
- R10: A clear strobe resets the consecutive count to 0. A result arriving in the same cycle as the clear counts from zero.
- R11: The pad drive output always equals the pending flag: 1 pulls the interrupt line low.
- R12: In cycles with neither a valid strobe nor a clear strobe, the consecutive count and the pending flag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid_i | input | 1 | One-cycle strobe marking a new conversion result |
| res_data_i | input | 16 | Conversion result |
| thr_low_i | input | 16 | Low threshold of the window |
| thr_high_i | input | 16 | High threshold of the window |
| persist_i | input | 4 | Consecutive outside results required; 0 means every result |
| irq_en_i | input | 1 | Proximity interrupt enable |
| irq_clr_i | input | 1 | One-cycle clear strobe from the register interface |
| int_drive_o | output | 1 | Open-drain pad enable; 1 pulls the active-low line low |
| irq_pending_o | output | 1 | Pending interrupt status bit |

## Verification
The assertions assume that the valid and clear strobes are synchronous to the clock and free of X after reset. They also assume that the thresholds and the persistence value are steady during the cycle in which a result is strobed. The properties do not require the low threshold to be at or below the high threshold, and the stimulus includes inverted windows. The stimulus changes every input only on the falling edge. It applies clears in three situations: alone, together with a qualifying result, and together with a non-qualifying result. In the randomized phase it mixes idle cycles with strobes, so that each hold property is exercised with inputs that change around it.

// File: rtl/prox_irq_pkg.sv
package prox_irq_pkg;

    // Where a result lies relative to the threshold window
    typedef enum logic [1:0] {
        WIN_INSIDE = 2'b00,
        WIN_BELOW  = 2'b01,
        WIN_ABOVE  = 2'b10
    } win_pos_e;

endpackage

// File: rtl/prox_win_cmp.sv
module prox_win_cmp
    import prox_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] low_i,
    input  logic [DATA_W-1:0] high_i,
    output win_pos_e          pos_o,
    output logic              outside_o
);

    logic below;
    logic above;

    always_comb begin
        // strict comparisons: a result equal to a threshold counts as inside
        below = (data_i < low_i);
        above = (data_i > high_i);
        if (below) begin
            pos_o = WIN_BELOW;
        end else if (above) begin
            pos_o = WIN_ABOVE;
        end else begin
            pos_o = WIN_INSIDE;
        end
        outside_o = (pos_o != WIN_INSIDE);
    end

endmodule

// File: rtl/prox_persist_cnt.sv
module prox_persist_cnt #(
    parameter int unsigned PERS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              outside_i,
    input  logic              clr_i,
    input  logic [PERS_W-1:0] persist_i,
    output logic              hit_o
);

    localparam logic [PERS_W-1:0] CNT_MAX  = '1;
    localparam logic [PERS_W-1:0] CNT_ZERO = '0;
    localparam logic [PERS_W-1:0] CNT_ONE  = PERS_W'(1);

    typedef struct packed {
        logic [PERS_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    logic [PERS_W-1:0] base;
    logic [PERS_W:0]   run_len;
    logic [PERS_W-1:0] sat_next;

    always_comb begin
        st_d = st_q;
        // a clear restarts the run before this cycle's result is counted
        base     = clr_i ? CNT_ZERO : st_q.cnt;
        run_len  = {1'b0, base} + {{PERS_W{1'b0}}, 1'b1};
        sat_next = (base == CNT_MAX) ? CNT_MAX : (base + CNT_ONE);
        hit_o    = 1'b0;
        if (valid_i) begin
            if (outside_i) begin
                st_d.cnt = sat_next;
            end else begin
                st_d.cnt = CNT_ZERO;
            end
            if (persist_i == CNT_ZERO) begin
                hit_o = 1'b1;
            end else if (outside_i && (run_len >= {1'b0, persist_i})) begin
                hit_o = 1'b1;
            end
        end else begin
            st_d.cnt = base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5
    inside_resets_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !outside_i) |=> (st_q.cnt == CNT_ZERO));

    // R6
    run_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && outside_i && !clr_i && (st_q.cnt == CNT_MAX)) |=> (st_q.cnt == CNT_MAX));

    // R10
    clear_resets_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !valid_i) |=> (st_q.cnt == CNT_ZERO));

    // R12
    idle_holds_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !clr_i) |=> $stable(st_q.cnt));

endmodule

// File: rtl/prox_irq_latch.sv
module prox_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic en_i,
    input  logic clr_i,
    output logic pending_o
);

    typedef struct packed {
        logic pending;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a new qualifying event outranks a clear in the same cycle
        if (hit_i && en_i) begin
            st_d.pending = 1'b1;
        end else if (clr_i) begin
            st_d.pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending_o = st_q.pending;

    // R7
    pending_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !clr_i) |=> pending_o);

    // R8
    disabled_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !pending_o) |=> !pending_o);

    // R9
    event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && en_i && clr_i) |=> pending_o);

    // R7
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit_i) |=> !pending_o);

endmodule

// File: rtl/prox_irq_gen.sv
module prox_irq_gen
    import prox_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned PERS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid_i,
    input  logic [DATA_W-1:0] res_data_i,
    input  logic [DATA_W-1:0] thr_low_i,
    input  logic [DATA_W-1:0] thr_high_i,
    input  logic [PERS_W-1:0] persist_i,
    input  logic              irq_en_i,
    input  logic              irq_clr_i,
    output logic              int_drive_o,
    output logic              irq_pending_o
);

    win_pos_e win_pos;
    logic     outside;
    logic     hit;
    logic     pending;

    prox_win_cmp #(.DATA_W(DATA_W)) u_cmp (
        .data_i    (res_data_i),
        .low_i     (thr_low_i),
        .high_i    (thr_high_i),
        .pos_o     (win_pos),
        .outside_o (outside)
    );

    prox_persist_cnt #(.PERS_W(PERS_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (res_valid_i),
        .outside_i (outside),
        .clr_i     (irq_clr_i),
        .persist_i (persist_i),
        .hit_o     (hit)
    );

    prox_irq_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit),
        .en_i      (irq_en_i),
        .clr_i     (irq_clr_i),
        .pending_o (pending)
    );

    assign irq_pending_o = pending;
    assign int_drive_o   = pending;

    // R3
    zero_persist_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_i && irq_en_i && (persist_i == '0)) |=> irq_pending_o);

    // R2
    outside_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_pos == WIN_BELOW) |-> (res_data_i < thr_low_i));

endmodule

// File: tb/prox_irq_gen_tb.sv
module prox_irq_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid_i = 1'b0;
    logic [15:0] res_data_i = '0;
    logic [15:0] thr_low_i = '0;
    logic [15:0] thr_high_i = '0;
    logic [3:0]  persist_i = '0;
    logic        irq_en_i = 1'b0;
    logic        irq_clr_i = 1'b0;
    logic        int_drive_o;
    logic        irq_pending_o;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural reference
    int  m_run = 0;
    bit  m_pend = 0;

    always #2.5 clk = ~clk;

    prox_irq_gen u_dut (
        .clk(clk), .rst_n(rst_n), .res_valid_i(res_valid_i), .res_data_i(res_data_i),
        .thr_low_i(thr_low_i), .thr_high_i(thr_high_i), .persist_i(persist_i),
        .irq_en_i(irq_en_i), .irq_clr_i(irq_clr_i),
        .int_drive_o(int_drive_o), .irq_pending_o(irq_pending_o)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run  <= 0;
            m_pend <= 0;
        end else begin
            int  start;
            bit  outw;
            bit  fire;
            start = irq_clr_i ? 0 : m_run;
            outw  = (int'(res_data_i) < int'(thr_low_i)) || (int'(res_data_i) > int'(thr_high_i));
            fire  = 0;
            if (res_valid_i) begin
                if (persist_i == 0) fire = 1;
                else if (outw && (start + 1 >= int'(persist_i))) fire = 1;
                m_run <= outw ? ((start >= 15) ? 15 : start + 1) : 0;
            end else begin
                m_run <= start;
            end
            if (fire && irq_en_i) m_pend <= 1;
            else if (irq_clr_i) m_pend <= 0;
        end
    end

    // per-cycle comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_checks++;
            if (irq_pending_o !== m_pend) begin
                n_fail++;
                $display("FAIL %s pending actual=%0b expected=%0b", cur_req, irq_pending_o, m_pend);
            end
            n_checks++;
            // R11
            if (int_drive_o !== m_pend) begin
                n_fail++;
                $display("FAIL R11 pad drive actual=%0b expected=%0b", int_drive_o, m_pend);
            end
        end
    end

    task automatic expect_pend(input bit exp, input string req);
        n_checks++;
        if (irq_pending_o !== exp) begin
            n_fail++;
            $display("FAIL %s pending actual=%0b expected=%0b", req, irq_pending_o, exp);
        end
    endtask

    task automatic push(input int v, input bit clr);
        @(negedge clk);
        res_valid_i = 1'b1;
        res_data_i  = 16'(v);
        irq_clr_i   = clr;
    endtask

    task automatic idle();
        @(negedge clk);
        res_valid_i = 1'b0;
        irq_clr_i   = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk);
        res_valid_i = 1'b0;
        irq_clr_i   = 1'b1;
        idle();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        expect_pend(1'b0, "R1");
        n_checks++;
        if (int_drive_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 pad drive actual=%0b expected=0", int_drive_o);
        end
        rst_n = 1'b1;
        thr_low_i = 16'd100;
        thr_high_i = 16'd200;
        irq_en_i = 1'b1;

        // R3: inside result still fires with persistence 0
        cur_req = "R3";
        persist_i = 4'd0;
        push(150, 0); idle();
        expect_pend(1'b1, "R3");

        // R7: holds, then clears
        cur_req = "R7";
        idle(); idle(); idle();
        expect_pend(1'b1, "R7");
        clear();
        expect_pend(1'b0, "R7");

        // R2 and R4: boundaries inside, third outside fires
        cur_req = "R4";
        persist_i = 4'd3;
        push(100, 0); push(200, 0); idle();
        expect_pend(1'b0, "R2");
        push(99, 0); push(201, 0); idle();
        expect_pend(1'b0, "R4");
        push(50, 0); idle();
        expect_pend(1'b1, "R4");
        clear();

        // R5: inside result restarts the run
        cur_req = "R5";
        persist_i = 4'd2;
        push(10, 0); push(150, 0); push(10, 0); idle();
        expect_pend(1'b0, "R5");
        push(10, 0); idle();
        expect_pend(1'b1, "R5");
        clear();

        // R12: idle cycles keep the run
        cur_req = "R12";
        push(10, 0);
        repeat (5) idle();
        expect_pend(1'b0, "R12");
        push(10, 0); idle();
        expect_pend(1'b1, "R12");
        clear();

        // R10: clear restarts the run
        cur_req = "R10";
        push(10, 0); clear();
        push(10, 0); idle();
        expect_pend(1'b0, "R10");
        push(10, 0); idle();
        expect_pend(1'b1, "R10");
        clear();

        // R9: clear together with a qualifying result
        cur_req = "R9";
        persist_i = 4'd1;
        push(10, 0); idle();
        expect_pend(1'b1, "R9");
        push(10, 1); idle();
        expect_pend(1'b1, "R9");
        clear();
        expect_pend(1'b0, "R9");

        // R8 and R6: disabled counting, then saturated run fires at once
        cur_req = "R8";
        irq_en_i = 1'b0;
        persist_i = 4'd15;
        repeat (20) push(10, 0);
        idle();
        expect_pend(1'b0, "R8");
        cur_req = "R6";
        irq_en_i = 1'b1;
        push(10, 0); idle();
        expect_pend(1'b1, "R6");
        clear();
        cur_req = "R8";
        irq_en_i = 1'b0;
        persist_i = 4'd0;
        push(150, 0); idle();
        expect_pend(1'b0, "R8");
        irq_en_i = 1'b1;

        // randomized mix around the thresholds, inverted windows included
        cur_req = "R4";
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (i % 97 == 0) persist_i = 4'($urandom_range(0, 15));
            if (i % 150 == 0) begin
                thr_low_i  = 16'($urandom_range(50, 150));
                thr_high_i = 16'($urandom_range(60, 200));
            end
            irq_en_i    = ($urandom_range(0, 9) != 0);
            res_valid_i = ($urandom_range(0, 2) != 0);
            res_data_i  = 16'($urandom_range(0, 260));
            irq_clr_i   = ($urandom_range(0, 11) == 0);
        end
        idle(); idle();
        finish_run();
    end

endmodule